// File: doc/BRIEF.md
# Sampling Converter Serial Port Emulator

This block imitates the digital face of a 16-bit sampling converter so that host-side serial logic can be exercised without the real device. The host drives a convert strobe, a serial clock and a serial data line. The block answers with serial data, an output-enable that stands in for a high-impedance pin, and a busy flag. A count of system-clock cycles stands in for the conversion. The value returned is taken from a test input at the instant of the convert edge. No analog behaviour is modelled.

All three host lines are sampled on the system clock, and their edges are detected against the previous sample. The level of the serial data line at the convert rising edge picks the mode. A high level selects chip-select mode. A low level selects chain mode, in which the upstream device's bits follow the local word; chain mode exists only when the chain option is built in. A second option, busy signalling, builds in an end-of-conversion indication on the data line.

Top module: `sar_port_emulator`

## Requirements
- R1: After reset, sdo_oe and busy are both 0.
- R2: A cnv rising edge seen while idle or reading latches sample_value and raises busy for exactly ceil(CONV_NS/CLK_NS) clock cycles. The default is 70 cycles.
- R3: Without busy signalling, sdo_oe is 0 for the whole conversion. sck falling edges during the conversion have no effect: the read that follows still starts at bit 15.
- R4: In chip-select mode, once busy is low and cnv is low, sdo shows bit 15 of the result. Each sck falling edge moves sdo to the next lower bit, one clock later. The result is straight binary, so 0x0000 and 0xFFFF come out unchanged.
- R5: In chip-select mode without busy signalling, sdo_oe drops one clock after the 16th sck falling edge.
- R6: In chip-select mode, a rising edge on sdi during a read drops sdo_oe at once, even before all bits are out.
- R7: The word read is the sample_value present at the cnv rising edge that started the conversion. Later changes to sample_value do not alter it.
- R8: A cnv rising edge during a conversion is ignored. It neither lengthens busy nor replaces the latched value.
- R9: With BUSY_IND=1 in chip-select mode, while busy is high and cnv is low, sdo_oe is 1 and sdo is 0. After the conversion, sdo is 1 until the first sck falling edge. The next 16 falling edges present bits 15 down to 0, and sdo_oe drops after the 17th falling edge.
- R10: With CHAIN_EN=1 and sdi low at the cnv rising edge, the read shifts out the 16 local bits. The value of sdi at each falling edge then follows, delayed by 16 falling edges. In this mode the output is not released by a count or by sdi.
- R11: Whenever cnv is high, sdo_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Convert strobe; when low it also enables the output |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Mode select, release request, or upstream chain data |
| sample_value | input | DATA_W | Test value converted at the cnv rising edge |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable (0 stands in for high impedance) |
| busy | output | 1 | High while a conversion runs |

## Verification
The bench targets the following corner cases:
- An off-by-one release, which would cut the 16th bit short or leave the line driven one fall too long.
- A conversion that counts one cycle too many or too few.
- A retrigger during conversion that wrongly restarts the timer or reloads the value.
- Sampling at the end of the conversion rather than at the edge, which would return a value changed after the edge.
- Serial clocks during the conversion that, if wrongly honoured, would skip the leading bits.
- In chain mode, an upstream bit delayed by the wrong number of falls, or a port that wrongly releases on sdi.
- In busy signalling, a missing leading 1, which would shift every later bit by one.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;
   typedef enum logic [1:0] {
      PORT_IDLE = 2'd0,
      PORT_CONV = 2'd1,
      PORT_READ = 2'd2
   } port_state_t;

   function automatic int unsigned cycles_for(input int unsigned t_ns, input int unsigned clk_ns);
      return (t_ns + clk_ns - 1) / clk_ns;
   endfunction
endpackage

// File: rtl/sar_emu_edge.sv
module sar_emu_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic evt
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin;
   end

   generate
      if (RISING) begin : g_rise
         assign evt = pin & ~prev_q;
      end else begin : g_fall
         assign evt = ~pin & prev_q;
      end
   endgenerate
endmodule

// File: rtl/sar_emu_timer.sv
module sar_emu_timer #(
   parameter int unsigned CONV_CYCLES = 70
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic running,
   output logic done
);
   localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CONV_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign running = run_q;
   assign done    = run_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (!run_q) begin
         if (start) begin
            run_q <= 1'b1;
            cnt_q <= LOAD_VAL;
         end
      end else if (cnt_q == '0) begin
         run_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/sar_emu_shifter.sv
module sar_emu_shifter #(
   parameter int unsigned DATA_W   = 16,
   parameter bit          BUSY_IND = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              load_marker,
   input  logic              shift_en,
   input  logic              shift_in,
   output logic              bit_out,
   output logic              last_shift
);
   localparam int unsigned CW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);
   localparam logic [CW-1:0] SAT_IDX  = CW'(DATA_W);

   logic [DATA_W-1:0] word_q;
   logic [CW-1:0]     done_q;
   logic              marker;
   logic              data_step;

   generate
      if (BUSY_IND) begin : g_marker
         logic marker_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        marker_q <= 1'b0;
            else if (load)     marker_q <= load_marker;
            else if (shift_en) marker_q <= 1'b0;
         end
         assign marker = marker_q;
      end else begin : g_no_marker
         logic unused_marker;
         assign unused_marker = load_marker;
         assign marker = 1'b0;
      end
   endgenerate

   assign data_step  = shift_en & ~marker;
   assign last_shift = data_step && (done_q == LAST_IDX);
   assign bit_out    = marker | word_q[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         done_q <= '0;
      end else if (load) begin
         word_q <= load_val;
         done_q <= '0;
      end else if (data_step) begin
         word_q <= {word_q[DATA_W-2:0], shift_in};
         if (done_q != SAT_IDX) done_q <= done_q + 1'b1;
      end
   end
endmodule

// File: rtl/sar_port_emulator.sv
module sar_port_emulator
   import sar_emu_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CLK_NS   = 10,
   parameter int unsigned CONV_NS  = 700,
   parameter bit          BUSY_IND = 1'b0,
   parameter bit          CHAIN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv,
   input  logic              sck,
   input  logic              sdi,
   input  logic [DATA_W-1:0] sample_value,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              busy
);
   localparam int unsigned CONV_CYCLES = cycles_for(CONV_NS, CLK_NS);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (CLK_NS == 0) begin : g_bad_clk
         $error("CLK_NS must be non-zero");
      end
      if (CONV_NS < 500 || CONV_NS > 1600) begin : g_bad_conv
         $error("CONV_NS must lie in 500..1600");
      end
   endgenerate

   port_state_t       state_q;
   logic [DATA_W-1:0] sample_q;
   logic              chain_q;
   logic              cnv_rise, sck_fall, sdi_rise;
   logic              tmr_run, tmr_done, start;
   logic              shift_en, last_shift, shift_bit;

   sar_emu_edge #(.RISING(1'b1)) u_cnv_edge (.clk(clk), .rst_n(rst_n), .pin(cnv), .evt(cnv_rise));
   sar_emu_edge #(.RISING(1'b0)) u_sck_edge (.clk(clk), .rst_n(rst_n), .pin(sck), .evt(sck_fall));
   sar_emu_edge #(.RISING(1'b1)) u_sdi_edge (.clk(clk), .rst_n(rst_n), .pin(sdi), .evt(sdi_rise));

   assign start = cnv_rise & ~tmr_run;

   sar_emu_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .running(tmr_run), .done(tmr_done)
   );

   generate
      if (CHAIN_EN) begin : g_chain
         logic mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     mode_q <= 1'b0;
            else if (start) mode_q <= ~sdi;
         end
         assign chain_q = mode_q;
      end else begin : g_cs_only
         assign chain_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sample_q <= '0;
      else if (start) sample_q <= sample_value;
   end

   assign shift_en = (state_q == PORT_READ) & sck_fall & ~cnv;

   sar_emu_shifter #(.DATA_W(DATA_W), .BUSY_IND(BUSY_IND)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .load(tmr_done), .load_val(sample_q), .load_marker(~chain_q),
      .shift_en(shift_en), .shift_in(sdi & chain_q),
      .bit_out(shift_bit), .last_shift(last_shift)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PORT_IDLE;
      end else if (start) begin
         state_q <= PORT_CONV;
      end else begin
         unique case (state_q)
            PORT_CONV: if (tmr_done) state_q <= PORT_READ;
            PORT_READ: if (!chain_q && (last_shift || sdi_rise)) state_q <= PORT_IDLE;
            default:   state_q <= state_q;
         endcase
      end
   end

   assign busy = (state_q == PORT_CONV);

   generate
      if (BUSY_IND) begin : g_busy_line
         assign sdo_oe = ~cnv & ((state_q == PORT_READ) | (busy & ~chain_q));
         assign sdo    = busy ? 1'b0 : shift_bit;
      end else begin : g_plain_line
         assign sdo_oe = ~cnv & (state_q == PORT_READ);
         assign sdo    = shift_bit;
      end
   endgenerate
endmodule

// File: rtl/sar_emu_checker.sv
module sar_emu_checker #(
   parameter int unsigned CONV_CYCLES = 70,
   parameter bit          BUSY_IND    = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic cnv,
   input logic sck,
   input logic busy,
   input logic sdo,
   input logic sdo_oe
);
   logic [31:0] run_q;
   logic        sck_d;
   logic        sfall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         sck_d <= 1'b0;
      end else begin
         run_q <= busy ? run_q + 1 : '0;
         sck_d <= sck;
      end
   end

   assign sfall = sck_d & ~sck;

   assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == CONV_CYCLES));

   assert_quiet_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!BUSY_IND && busy) |-> !sdo_oe);

   assert_sdo_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && $past(sdo_oe) && !$past(sfall) && !$past(busy)) |-> $stable(sdo));

   assert_cnv_high_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnv |-> !sdo_oe);
endmodule

bind sar_port_emulator sar_emu_checker #(
   .CONV_CYCLES(CONV_CYCLES), .BUSY_IND(BUSY_IND)
) u_checker (
   .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck),
   .busy(busy), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/sar_port_emulator_tb.sv
module sar_port_emulator_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int EXP_CONV   = 70;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnv = 1'b0;
   logic        sck = 1'b1;
   logic        sdi = 1'b1;
   logic [15:0] sample_value = '0;
   logic        sdo_a, oe_a, busy_a;
   logic        sdo_b, oe_b, busy_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_port_emulator #(.DATA_W(16), .CLK_NS(CLK_PERIOD), .CONV_NS(700),
                       .BUSY_IND(1'b0), .CHAIN_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
      .sample_value(sample_value), .sdo(sdo_a), .sdo_oe(oe_a), .busy(busy_a));

   sar_port_emulator #(.DATA_W(16), .CLK_NS(CLK_PERIOD), .CONV_NS(700),
                       .BUSY_IND(1'b1), .CHAIN_EN(1'b0)) dut_b (
      .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
      .sample_value(sample_value), .sdo(sdo_b), .sdo_oe(oe_b), .busy(busy_b));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_plain(input logic [15:0] v, input int f);
      return v[15-f];
   endfunction

   function automatic bit exp_marked(input logic [15:0] v, input int f);
      return (f == 0) ? 1'b1 : v[16-f];
   endfunction

   task automatic do_conv(input bit lvl, input logic [15:0] v, input bit hold_high,
                          input bit retrig, input bit tog_sck);
      int n;
      @(negedge clk);
      cnv = 1'b1; sdi = lvl; sample_value = v;
      @(negedge clk);
      sample_value = ~v; // R7: changed after the edge
      n = 0;
      while (busy_a && n < 1000) begin
         n++;
         check(!oe_a, "R3 oe during conversion", oe_a, 0);
         if (!cnv) begin
            check(oe_b && !sdo_b, "R9 busy low on line", {oe_b, sdo_b}, 2);
         end
         if (n == 2 && !hold_high) cnv = 1'b0;
         if (retrig) begin
            if (n == 5) cnv = 1'b0;
            if (n == 8) begin cnv = 1'b1; sample_value = v ^ 16'h5A5A; end
            if (n == 11) cnv = 1'b0;
         end
         if (tog_sck) sck = ~sck;
         @(negedge clk);
      end
      sck = 1'b1;
      check(n == EXP_CONV, retrig ? "R8 busy length with retrigger" : "R2 busy length", n, EXP_CONV);
      if (hold_high) begin
         check(!oe_a && !oe_b, "R11 cnv high keeps output off", {oe_a, oe_b}, 0);
         cnv = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic do_read(input logic [15:0] v, input int nfalls, input int rel_at, input string tag);
      check(oe_a && sdo_a == exp_plain(v, 0), {tag, " first bit"}, {oe_a, sdo_a}, {1'b1, exp_plain(v, 0)});
      check(oe_b && sdo_b == 1'b1, "R9 leading one", {oe_b, sdo_b}, 3);
      if (rel_at > 0) sdi = 1'b0;
      for (int f = 1; f <= nfalls; f++) begin
         if (f == rel_at) begin
            sdi = 1'b1;
            @(negedge clk);
            check(!oe_a && !oe_b, "R6 sdi rise releases", {oe_a, oe_b}, 0);
            return;
         end
         sck = 1'b0;
         @(negedge clk);
         if (f < 16)
            check(oe_a && sdo_a == exp_plain(v, f), {tag, " bit"}, {oe_a, sdo_a}, {1'b1, exp_plain(v, f)});
         else if (f == 16)
            check(!oe_a, "R5 release after 16th fall", oe_a, 0);
         if (f <= 16)
            check(oe_b && sdo_b == exp_marked(v, f), "R9 marked bit", {oe_b, sdo_b}, {1'b1, exp_marked(v, f)});
         else if (f == 17)
            check(!oe_b, "R9 release after 17th fall", oe_b, 0);
         sck = 1'b1;
         @(negedge clk);
      end
   endtask

   task automatic do_chain(input logic [15:0] v);
      logic [32:1] up;
      up = {$urandom, $urandom} [31:0];
      check(oe_a && sdo_a == v[15], "R10 chain first bit", {oe_a, sdo_a}, {1'b1, v[15]});
      for (int f = 1; f <= 32; f++) begin
         sck = 1'b0; sdi = up[f];
         @(negedge clk);
         if (f < 16)
            check(oe_a && sdo_a == v[15-f], "R10 chain local bit", {oe_a, sdo_a}, {1'b1, v[15-f]});
         else
            check(oe_a && sdo_a == up[f-15], "R10 chain passed bit", {oe_a, sdo_a}, {1'b1, up[f-15]});
         sck = 1'b1;
         @(negedge clk);
      end
   endtask

   initial begin
      logic [15:0] rv;
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      check(!oe_a && !busy_a && !oe_b && !busy_b, "R1 reset state", {oe_a, busy_a, oe_b, busy_b}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!oe_a && !busy_a, "R1 after reset release", {oe_a, busy_a}, 0);

      do_conv(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0); do_read(16'h0000, 17, 0, "R4 zero code");
      do_conv(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0); do_read(16'hFFFF, 17, 0, "R4 full scale");
      do_conv(1'b1, 16'hA5C3, 1'b0, 1'b0, 1'b1); do_read(16'hA5C3, 17, 0, "R3 after sck in conversion");
      do_conv(1'b1, 16'h8001, 1'b1, 1'b0, 1'b0); do_read(16'h8001, 17, 0, "R11 read after cnv low");
      do_conv(1'b1, 16'h1234, 1'b0, 1'b1, 1'b0); do_read(16'h1234, 17, 0, "R8 value kept");
      do_conv(1'b1, 16'h7E81, 1'b0, 1'b0, 1'b0); do_read(16'h7E81, 17, 6, "R6 early stop");
      for (int i = 0; i < 6; i++) begin
         rv = 16'($urandom);
         do_conv(1'b1, rv, 1'b0, 1'b0, 1'b0); do_read(rv, 17, 0, "R7 random word");
      end
      rv = 16'($urandom);
      do_conv(1'b0, rv, 1'b0, 1'b0, 1'b0); do_chain(rv);
      do_conv(1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b0); do_read(16'h0F0F, 17, 0, "R4 after chain");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule